// File: doc/BRIEF.md
# Branch and Trap Program Counter Unit

This block holds the program counter of a 16-bit word-addressed machine. A fetch strobe advances the counter by one word. An execute strobe, with the instruction word, makes the block either settle a conditional branch or run a trap. A branch tests a three-bit mask against the current negative, zero and positive flags. When it is taken, the new counter keeps the current page number and takes the instruction's nine-bit offset as the low part. The counter has already advanced past the branch when this happens.

A trap saves the current (already advanced) counter into link register 7 through a one-cycle write request. It then reads the routine's start address from a vector table in the lowest 256 words of memory. The read uses a request/ready port, and the word returned becomes the new counter. A done pulse marks the end of each executed instruction. Opcodes other than branch and trap complete at once and leave the counter alone.

Top module: `branch_trap_pc`

## Requirements
- R1: After reset `pc_o` is 16'h3000, and `mem_req_o`, `r7_we_o` and `done_o` are low.
- R2: A `fetch_i` pulse while idle, with `exec_i` low, adds one to `pc_o` at the next clock edge.
- R3: An instruction with bits [15:12] = 4'b0000 is a branch. Bit 11 selects N, bit 10 selects Z and bit 9 selects P. It is taken when any selected flag is set. If taken, `pc_o` becomes {pc_o[15:9], instr[8:0]} at the next edge.
- R4: A branch mask of 3'b000 is never taken. A mask of 3'b111 is taken whenever any flag is set.
- R5: Every executed branch, taken or not, raises `done_o` in the cycle in which `exec_i` is high. A branch that is not taken leaves `pc_o` unchanged.
- R6: An instruction with bits [15:12] = 4'b1111 and bits [11:8] = 4'b0000 is a trap. In its execute cycle, `r7_we_o` is high for exactly one cycle and `r7_data_o` equals the current `pc_o`.
- R7: From the cycle after a trap's execute cycle, `mem_req_o` stays high with `mem_addr_o` = {8'h00, instr[7:0]}, held stable until `mem_rdy_i` is seen.
- R8: In the cycle in which `mem_req_o` and `mem_rdy_i` are both high, `done_o` is high. At the next edge `pc_o` takes `mem_rdata_i` and `mem_req_o` falls.
- R9: A trap opcode with nonzero bits [11:8] is illegal. It raises `done_o` in its execute cycle, writes nothing to R7, issues no read and leaves `pc_o` unchanged.
- R10: While a trap read is pending, `fetch_i` and `exec_i` are ignored and `pc_o` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_i | input | 1 | Fetch strobe, advances the counter |
| exec_i | input | 1 | Execute strobe for `instr_i` |
| instr_i | input | 16 | Instruction word |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_p_i | input | 1 | Positive flag |
| mem_req_o | output | 1 | Vector table read request |
| mem_addr_o | output | 16 | Vector table read address |
| mem_rdata_i | input | 16 | Read data |
| mem_rdy_i | input | 1 | Read data valid |
| pc_o | output | 16 | Program counter |
| r7_we_o | output | 1 | Link register write request |
| r7_data_o | output | 16 | Link value |
| done_o | output | 1 | Instruction complete |

## Verification
`done_o`, `r7_we_o` and `r7_data_o` answer in the same cycle as the strobe that causes them. The bench drives each strobe after a falling edge and samples these outputs one time step later, before the next rising edge. `pc_o` and `mem_req_o` change at the rising edge after the strobe, so the bench samples them at the following falling edge. A trap read is held off for several cycles to show that the request and the counter do not move while the read is pending. The ready cycle is then checked for `done_o`, and the cycle after it for the new counter.

// File: rtl/brtrap_pkg.sv
package brtrap_pkg;
  typedef enum logic [1:0] {
    PC_HOLD = 2'd0,
    PC_INC  = 2'd1,
    PC_BR   = 2'd2,
    PC_VEC  = 2'd3
  } pc_sel_e;

  typedef enum logic {
    TS_IDLE = 1'b0,
    TS_WAIT = 1'b1
  } trap_st_e;

  localparam logic [3:0] OP_BRANCH = 4'b0000;
  localparam logic [3:0] OP_TRAP   = 4'b1111;
endpackage

// File: rtl/branch_cond.sv
module branch_cond #(
  parameter int FLAG_W = 3
) (
  input  logic [FLAG_W-1:0] mask_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              take_o
);
  logic [FLAG_W-1:0] hit;
  for (genvar g = 0; g < FLAG_W; g++) begin : g_hit
    assign hit[g] = mask_i[g] & flags_i[g];
  end
  assign take_o = |hit;
endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import brtrap_pkg::*;
#(
  parameter int XLEN  = 16,
  parameter int VEC_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic            rdy_i,
  output logic            busy_o,
  output logic            load_o,
  output logic [XLEN-1:0] addr_o
);
  localparam int PAD_W = XLEN - VEC_W;

  trap_st_e         st_q;
  logic [VEC_W-1:0] vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= TS_IDLE;
      vec_q <= '0;
    end else begin
      unique case (st_q)
        TS_IDLE: if (start_i) begin
          st_q  <= TS_WAIT;
          vec_q <= vec_i;
        end
        TS_WAIT: if (rdy_i) st_q <= TS_IDLE;
        default: st_q <= TS_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q == TS_WAIT);
  assign load_o = busy_o & rdy_i;
  assign addr_o = {{PAD_W{1'b0}}, vec_q};
endmodule

// File: rtl/pc_next.sv
module pc_next
  import brtrap_pkg::*;
#(
  parameter int          XLEN     = 16,
  parameter int          OFF_W    = 9,
  parameter logic [15:0] RESET_PC = 16'h3000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  pc_sel_e         sel_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [XLEN-1:0] vec_pc_i,
  output logic [XLEN-1:0] pc_o
);
  localparam int PAGE_W = XLEN - OFF_W;

  logic [XLEN-1:0] pc_q, pc_d;

  always_comb begin
    unique case (sel_i)
      PC_INC:  pc_d = pc_q + XLEN'(1);
      PC_BR:   pc_d = {pc_q[XLEN-1 -: PAGE_W], off_i};
      PC_VEC:  pc_d = vec_pc_i;
      default: pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= XLEN'(RESET_PC);
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/branch_trap_pc.sv
module branch_trap_pc
  import brtrap_pkg::*;
#(
  parameter int          XLEN     = 16,
  parameter int          OFF_W    = 9,
  parameter int          VEC_W    = 8,
  parameter logic [15:0] RESET_PC = 16'h3000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fetch_i,
  input  logic            exec_i,
  input  logic [XLEN-1:0] instr_i,
  input  logic            flag_n_i,
  input  logic            flag_z_i,
  input  logic            flag_p_i,
  output logic            mem_req_o,
  output logic [XLEN-1:0] mem_addr_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  input  logic            mem_rdy_i,
  output logic [XLEN-1:0] pc_o,
  output logic            r7_we_o,
  output logic [XLEN-1:0] r7_data_o,
  output logic            done_o
);
  localparam int OP_LSB  = XLEN - 4;
  localparam int MASK_W  = 3;
  localparam int RSV_W   = OP_LSB - VEC_W;

  logic [3:0]        opcode;
  logic              is_br, trap_ok, take, idle, exe, start, busy, load;
  pc_sel_e           sel;

  assign opcode  = instr_i[XLEN-1 -: 4];
  assign is_br   = (opcode == OP_BRANCH);
  assign trap_ok = (opcode == OP_TRAP) && (instr_i[OP_LSB-1 -: RSV_W] == '0);

  branch_cond #(.FLAG_W(MASK_W)) u_cond (
    .mask_i  (instr_i[OFF_W +: MASK_W]),
    .flags_i ({flag_n_i, flag_z_i, flag_p_i}),
    .take_o  (take)
  );

  assign idle  = ~busy;
  assign exe   = exec_i & idle;
  assign start = exe & trap_ok;

  trap_seq #(.XLEN(XLEN), .VEC_W(VEC_W)) u_trap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .vec_i   (instr_i[VEC_W-1:0]),
    .rdy_i   (mem_rdy_i),
    .busy_o  (busy),
    .load_o  (load),
    .addr_o  (mem_addr_o)
  );

  // execute beats fetch; nothing moves while a vector read is pending
  always_comb begin
    if (load)                            sel = PC_VEC;
    else if (exe && is_br && take)       sel = PC_BR;
    else if (idle && fetch_i && !exec_i) sel = PC_INC;
    else                                 sel = PC_HOLD;
  end

  pc_next #(.XLEN(XLEN), .OFF_W(OFF_W), .RESET_PC(RESET_PC)) u_pc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel),
    .off_i    (instr_i[OFF_W-1:0]),
    .vec_pc_i (mem_rdata_i),
    .pc_o     (pc_o)
  );

  assign mem_req_o = busy;
  assign r7_we_o   = start;
  assign r7_data_o = pc_o;
  assign done_o    = (exe & ~start) | load;
endmodule

// File: rtl/branch_trap_pc_chk.sv
module branch_trap_pc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        exec_i,
  input logic [15:0] instr_i,
  input logic        mem_req_o,
  input logic [15:0] mem_addr_o,
  input logic [15:0] mem_rdata_i,
  input logic        mem_rdy_i,
  input logic [15:0] pc_o,
  input logic        r7_we_o,
  input logic        done_o
);
  // R7
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rdy_i |=> mem_req_o && $stable(mem_addr_o));
  // R10
  pc_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rdy_i |=> $stable(pc_o));
  // R8
  vec_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_rdy_i |-> done_o);
  // R8
  vec_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_rdy_i |=> !mem_req_o && pc_o == $past(mem_rdata_i));
  // R6
  link_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r7_we_o |=> !r7_we_o && mem_req_o);
  // R4
  mask_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i && !mem_req_o && instr_i[15:9] == 7'd0 |-> done_o ##1 $stable(pc_o));
  // R9
  done_link_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && r7_we_o));
endmodule

bind branch_trap_pc branch_trap_pc_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .exec_i      (exec_i),
  .instr_i     (instr_i),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_rdata_i (mem_rdata_i),
  .mem_rdy_i   (mem_rdy_i),
  .pc_o        (pc_o),
  .r7_we_o     (r7_we_o),
  .done_o      (done_o)
);

// File: tb/tb_branch_trap_pc.sv
module tb_branch_trap_pc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch = 1'b0, exec = 1'b0;
  logic [15:0] instr = '0;
  logic        fn = 1'b0, fz = 1'b0, fp = 1'b0;
  logic        mem_req, r7_we, done, mem_rdy = 1'b0;
  logic [15:0] mem_addr, mem_rdata = '0, pc, r7_data;
  int checks = 0, fails = 0;
  logic [15:0] model_pc;

  always #2 clk = ~clk;

  branch_trap_pc dut (
    .clk_i(clk), .rst_ni(rst_n), .fetch_i(fetch), .exec_i(exec), .instr_i(instr),
    .flag_n_i(fn), .flag_z_i(fz), .flag_p_i(fp),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .mem_rdy_i(mem_rdy),
    .pc_o(pc), .r7_we_o(r7_we), .r7_data_o(r7_data), .done_o(done)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_fetch();
    @(negedge clk); fetch = 1'b1;
    @(negedge clk); fetch = 1'b0;
    model_pc = model_pc + 16'd1;
    chk("R2 fetch", pc, model_pc);
  endtask

  // {instr, n, z, p}
  localparam logic [18:0] VECS [8] = '{
    {16'b0000_000_001010101, 3'b111},
    {16'b0000_111_000010000, 3'b001},
    {16'b0000_100_111100000, 3'b100},
    {16'b0000_100_000000011, 3'b010},
    {16'b0000_011_101010101, 3'b010},
    {16'b0000_101_000000111, 3'b010},
    {16'b0000_001_011110000, 3'b001},
    {16'b0000_110_000001111, 3'b001}
  };

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    model_pc = 16'h3000;
    #5;
    // R1 reset state
    chk("R1 pc", pc, 16'h3000);
    chk("R1 req", {15'd0, mem_req}, 16'd0);
    chk("R1 done/we", {14'd0, done, r7_we}, 16'd0);
    @(negedge clk); rst_n = 1'b1;

    do_fetch();
    do_fetch();

    foreach (VECS[i]) begin
      logic [15:0] ins;
      logic [2:0]  msk, flg;
      logic        tk;
      do_fetch();
      ins = VECS[i][18:3];
      flg = VECS[i][2:0];
      msk = ins[11:9];
      tk  = |(msk & flg);
      @(negedge clk);
      instr = ins; {fn, fz, fp} = flg; exec = 1'b1;
      #1;
      chk("R5 branch done", {15'd0, done}, 16'd1);
      @(negedge clk); exec = 1'b0;
      if (tk) model_pc = {model_pc[15:9], ins[8:0]};
      chk(tk ? "R3 taken pc" : (msk == 3'b000 ? "R4 mask zero pc" : "R5 not taken pc"),
          pc, model_pc);
    end

    // R6/R7/R8/R10 trap x23
    do_fetch();
    @(negedge clk);
    instr = 16'hF023; exec = 1'b1;
    #1;
    chk("R6 r7 we", {15'd0, r7_we}, 16'd1);
    chk("R6 r7 data", r7_data, model_pc);
    chk("R6 no done", {15'd0, done}, 16'd0);
    @(negedge clk); exec = 1'b0;
    chk("R6 we pulse", {15'd0, r7_we}, 16'd0);
    chk("R7 req", {15'd0, mem_req}, 16'd1);
    chk("R7 addr", mem_addr, 16'h0023);
    fetch = 1'b1; exec = 1'b1; instr = 16'b0000_111_000000000; {fn, fz, fp} = 3'b001;
    @(negedge clk);
    @(negedge clk);
    fetch = 1'b0; exec = 1'b0;
    chk("R10 pc hold", pc, model_pc);
    chk("R7 addr stable", mem_addr, 16'h0023);
    chk("R7 req held", {15'd0, mem_req}, 16'd1);
    mem_rdata = 16'h0400; mem_rdy = 1'b1;
    #1;
    chk("R8 done", {15'd0, done}, 16'd1);
    @(negedge clk); mem_rdy = 1'b0;
    model_pc = 16'h0400;
    chk("R8 pc", pc, model_pc);
    chk("R8 req drop", {15'd0, mem_req}, 16'd0);

    // R9 illegal trap
    @(negedge clk);
    instr = 16'hF125; exec = 1'b1;
    #1;
    chk("R9 done", {15'd0, done}, 16'd1);
    chk("R9 no we", {15'd0, r7_we}, 16'd0);
    @(negedge clk); exec = 1'b0;
    chk("R9 pc", pc, model_pc);
    chk("R9 no req", {15'd0, mem_req}, 16'd0);

    // R4 mask 111 with negative flag
    @(negedge clk);
    instr = 16'b0000_111_110000001; {fn, fz, fp} = 3'b100; exec = 1'b1;
    @(negedge clk); exec = 1'b0;
    model_pc = {model_pc[15:9], 9'b110000001};
    chk("R4 mask all pc", pc, model_pc);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule